// File: doc/BRIEF.md
# Paged Host Memory Window Extender

This block sits in an FPGA between the asynchronous external memory bus of a signal processor and a wider memory controller. The host bus carries only a 20-bit word address, byte lanes chosen by byte enables, and a 32-bit data path. Every operation is a plain read or write of a memory-mapped location. The block widens the host address by taking chip-select identity, two spare control lines, or a software-written page latch, and builds a full byte address from them. It then issues one request to a simple downstream memory port.

One of two address-widening schemes is fixed by the `PAGE_MODE` parameter when the design is built. In segment mode, both chip-select spaces reach memory. The upper chip-select and the two control lines form a three-bit segment number that sits directly above the word address. In page mode, all memory traffic goes through the lower chip-select window. The upper chip-select space holds a six-bit page register, and that register supplies the address bits above the word address. The host selects a page by writing this register before the accesses that depend on it.

A four-state controller sequences each access. The states are `ST_IDLE`, `ST_ISSUE`, `ST_WAIT` and `ST_REPLY`. An accepted memory request moves from ST_IDLE to ST_ISSUE. ST_ISSUE moves to ST_REPLY if ready is already present, and to ST_WAIT otherwise. ST_WAIT moves to ST_REPLY when ready arrives. A page-register access moves straight from ST_IDLE to ST_REPLY. ST_REPLY always returns to ST_IDLE. While the controller is out of ST_IDLE, the host's strobe is held off by `hst_busy`.

Top module: `paged_mem_window`

## Requirements
- R1: After reset the block is idle: `hst_busy`, `hst_done` and `mem_valid` are 0, and in page mode the page register reads back as 0.
- R2: In segment mode, a request with `hst_cs_lo` or `hst_cs_hi` is a memory access. The byte address is {hst_cs_hi, hst_ctl[1], hst_ctl[0], hst_word, 2'b00}, zero-extended to 28 bits. This places segment number s (0..7) at byte address bits 24:22. The lower chip-select with both control lines low is segment 0, and the upper chip-select with both lines high is segment 7. If both chip-selects are asserted, the upper one wins.
- R3: In page mode, a request on `hst_cs_lo` alone is a memory access with byte address {page[5:0], hst_word, 2'b00}. The `hst_ctl` lines have no effect on the address.
- R4: In page mode, a request on `hst_cs_hi` reaches the page register and issues no memory request. A write loads `hst_wdata[5:0]`. A read returns the page in bits 5:0 with bits 31:6 zero. Either way, `hst_done` pulses in the cycle after acceptance.
- R5: `mem_valid` is high for exactly one cycle, in the cycle after a memory request is accepted. In that cycle `mem_we`, `mem_be` and `mem_wdata` equal the host's values at acceptance, so partial byte enables pass through unchanged.
- R6: `mem_ready` is taken in the `mem_valid` cycle or in any later cycle. `hst_done` pulses for one cycle in the next cycle, and `hst_rdata` then holds the `mem_rdata` value sampled with ready.
- R7: `hst_busy` is high from the cycle after acceptance through the `hst_done` cycle. Any request made while busy is ignored, including a page-register write. A new page therefore never changes an access already in flight; it applies from the next accepted access.
- R8: A request with neither chip-select asserted is ignored: no memory request, no `hst_done`, and `hst_busy` stays 0.
- R9: `mem_addr` stays constant from acceptance until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request, sampled while idle |
| hst_cs_lo | input | 1 | Lower chip-select space |
| hst_cs_hi | input | 1 | Upper chip-select space |
| hst_ctl | input | 2 | Spare control lines (segment bits in segment mode) |
| hst_word | input | 20 | Host word address |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data returned to host |
| hst_busy | output | 1 | Host strobe hold-off while an access runs |
| hst_done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | One-cycle downstream request pulse |
| mem_we | output | 1 | Downstream write flag |
| mem_addr | output | 28 | Downstream byte address |
| mem_be | output | 4 | Downstream byte enables |
| mem_wdata | output | 32 | Downstream write data |
| mem_ready | input | 1 | Downstream completion |
| mem_rdata | input | 32 | Downstream read data |

## Verification
Some rules hold on every cycle of any run, and the assertions check those. The request and completion pulses each last a single cycle. A request only appears while busy. The downstream address stays frozen for the whole access. A request with no chip-select never makes the block busy. Other behaviour depends on values the host chose earlier, and only the bench scenarios can show it. These include the mapping of all eight segment codes to their byte addresses, the page value that governs an access, the zero-extended page readback, a page write refused while an access is in flight, and partial byte enables passing through to the memory port.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_REPLY = 2'd3
    } pmw_state_e;
endpackage

// File: rtl/pmw_addr_map.sv
// Builds the downstream byte address from the host word address plus
// either the segment code (chip-select and control lines) or the page.
module pmw_addr_map #(
    parameter int WORD_AW   = 20,
    parameter int CTL_W     = 2,
    parameter int PAGE_W    = 6,
    parameter int LANE_AW   = 2,
    parameter bit PAGE_MODE = 1'b0,
    localparam int MEM_AW   = PAGE_W + WORD_AW + LANE_AW,
    localparam int SEG_PAD  = PAGE_W - CTL_W - 1
) (
    input  logic               cs_hi,
    input  logic [CTL_W-1:0]   ctl,
    input  logic [WORD_AW-1:0] word,
    input  logic [PAGE_W-1:0]  page,
    output logic [MEM_AW-1:0]  byte_addr
);
    generate
        if (PAGE_MODE) begin : g_page
            logic unused_seg;
            assign unused_seg = cs_hi ^ (^ctl);
            assign byte_addr  = {page, word, {LANE_AW{1'b0}}};
        end else begin : g_seg
            logic unused_page;
            assign unused_page = ^page;
            assign byte_addr   = {{SEG_PAD{1'b0}}, cs_hi, ctl, word, {LANE_AW{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/pmw_page_reg.sv
// Page latch: holds its value until written again; reads zero-extended.
module pmw_page_reg #(
    parameter int PAGE_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] rd_word
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:PAGE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    page <= '0;
        else if (load) page <= wdata[PAGE_W-1:0];
    end

    assign rd_word = {{(DATA_W-PAGE_W){1'b0}}, page};
endmodule

// File: rtl/pmw_ctrl.sv
// Access sequencer: idle -> issue -> (wait) -> reply -> idle.
module pmw_ctrl
    import pmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic is_mem,
    input  logic is_page,
    input  logic mem_ready,
    output logic take_mem,
    output logic take_page,
    output logic rd_cap,
    output logic mem_valid,
    output logic busy,
    output logic done
);
    pmw_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        take_mem  = 1'b0;
        take_page = 1'b0;
        rd_cap    = 1'b0;
        mem_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (req && is_page) begin
                    take_page = 1'b1;
                    state_nx  = ST_REPLY;
                end else if (req && is_mem) begin
                    take_mem = 1'b1;
                    state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    rd_cap   = 1'b1;
                    state_nx = ST_REPLY;
                end else begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_ready) begin
                    rd_cap   = 1'b1;
                    state_nx = ST_REPLY;
                end
            end
            ST_REPLY: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/paged_mem_window.sv
module paged_mem_window #(
    parameter int WORD_AW   = 20,
    parameter int CTL_W     = 2,
    parameter int PAGE_W    = 6,
    parameter int DATA_W    = 32,
    parameter bit PAGE_MODE = 1'b0,
    localparam int BE_W     = DATA_W / 8,
    localparam int LANE_AW  = $clog2(BE_W),
    localparam int MEM_AW   = PAGE_W + WORD_AW + LANE_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_cs_lo,
    input  logic               hst_cs_hi,
    input  logic [CTL_W-1:0]   hst_ctl,
    input  logic [WORD_AW-1:0] hst_word,
    input  logic               hst_we,
    input  logic [BE_W-1:0]    hst_be,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic [DATA_W-1:0]  hst_rdata,
    output logic               hst_busy,
    output logic               hst_done,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [BE_W-1:0]    mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata
);
    logic              is_mem, is_page;
    logic              take_mem, take_page, rd_cap;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] page_word;
    logic [MEM_AW-1:0] map_addr;

    generate
        if (PAGE_MODE) begin : g_pg
            assign is_page = hst_cs_hi;
            assign is_mem  = hst_cs_lo & ~hst_cs_hi;
            pmw_page_reg #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_page (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (take_page & hst_we),
                .wdata   (hst_wdata),
                .page    (page),
                .rd_word (page_word)
            );
        end else begin : g_sg
            assign is_page   = 1'b0;
            assign is_mem    = hst_cs_lo | hst_cs_hi;
            assign page      = '0;
            assign page_word = '0;
        end
    endgenerate

    pmw_addr_map #(
        .WORD_AW(WORD_AW), .CTL_W(CTL_W), .PAGE_W(PAGE_W),
        .LANE_AW(LANE_AW), .PAGE_MODE(PAGE_MODE)
    ) u_map (
        .cs_hi     (hst_cs_hi),
        .ctl       (hst_ctl),
        .word      (hst_word),
        .page      (page),
        .byte_addr (map_addr)
    );

    pmw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (hst_req),
        .is_mem    (is_mem),
        .is_page   (is_page),
        .mem_ready (mem_ready),
        .take_mem  (take_mem),
        .take_page (take_page),
        .rd_cap    (rd_cap),
        .mem_valid (mem_valid),
        .busy      (hst_busy),
        .done      (hst_done)
    );

    // Request capture: address and page are frozen at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
        end else if (take_mem) begin
            mem_addr  <= map_addr;
            mem_be    <= hst_be;
            mem_we    <= hst_we;
            mem_wdata <= hst_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hst_rdata <= '0;
        else if (rd_cap)               hst_rdata <= mem_rdata;
        else if (take_page && !hst_we) hst_rdata <= page_word;
    end
endmodule

// File: rtl/paged_mem_window_chk.sv
module paged_mem_window_chk #(
    parameter int MEM_AW = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_req,
    input logic              hst_cs_lo,
    input logic              hst_cs_hi,
    input logic              hst_busy,
    input logic              hst_done,
    input logic              mem_valid,
    input logic [MEM_AW-1:0] mem_addr
);
    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !mem_valid);

    a_r5_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> hst_busy);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done);

    a_r7_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |-> hst_busy);

    a_r8_no_select_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_busy && hst_req && !hst_cs_lo && !hst_cs_hi) |=> !hst_busy);

    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_busy && !hst_done) |=> $stable(mem_addr));
endmodule

bind paged_mem_window paged_mem_window_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_req   (hst_req),
    .hst_cs_lo (hst_cs_lo),
    .hst_cs_hi (hst_cs_hi),
    .hst_busy  (hst_busy),
    .hst_done  (hst_done),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr)
);

// File: tb/paged_mem_window_test.sv
`timescale 1ns/1ps
module paged_mem_window_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_s = 0, req_p = 0, cs_lo = 0, cs_hi = 0, we = 0;
    logic [1:0]  ctl = 0;
    logic [19:0] word = 0;
    logic [3:0]  be = 0;
    logic [31:0] wdata = 0, mrdata = 0;
    logic        rdy_s = 0, rdy_p = 0;

    logic [31:0] s_rdata, p_rdata, s_wd, p_wd;
    logic        s_busy, s_done, s_valid, s_we, p_busy, p_done, p_valid, p_we;
    logic [27:0] s_addr, p_addr;
    logic [3:0]  s_be, p_be;

    paged_mem_window #(.PAGE_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .hst_req(req_s), .hst_cs_lo(cs_lo), .hst_cs_hi(cs_hi),
        .hst_ctl(ctl), .hst_word(word), .hst_we(we), .hst_be(be), .hst_wdata(wdata),
        .hst_rdata(s_rdata), .hst_busy(s_busy), .hst_done(s_done), .mem_valid(s_valid),
        .mem_we(s_we), .mem_addr(s_addr), .mem_be(s_be), .mem_wdata(s_wd),
        .mem_ready(rdy_s), .mem_rdata(mrdata));

    paged_mem_window #(.PAGE_MODE(1'b1)) uut_pg (
        .clk(clk), .rst_n(rst_n), .hst_req(req_p), .hst_cs_lo(cs_lo), .hst_cs_hi(cs_hi),
        .hst_ctl(ctl), .hst_word(word), .hst_we(we), .hst_be(be), .hst_wdata(wdata),
        .hst_rdata(p_rdata), .hst_busy(p_busy), .hst_done(p_done), .mem_valid(p_valid),
        .mem_we(p_we), .mem_addr(p_addr), .mem_be(p_be), .mem_wdata(p_wd),
        .mem_ready(rdy_p), .mem_rdata(mrdata));

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        hi;
        logic [1:0]  ctl;
        logic [19:0] word;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        logic [27:0] exp_addr;
    } vec_t;

    // R2 segment table: segment s lands at byte address s<<22 plus word*4.
    localparam vec_t VECS [8] = '{
        '{1'b0, 2'b00, 20'hABCD, 4'b1111, 1'b1, 32'h1111_0000, 28'h002AF34},
        '{1'b0, 2'b01, 20'hABCD, 4'b0001, 1'b1, 32'h1111_0001, 28'h042AF34},
        '{1'b0, 2'b10, 20'hABCD, 4'b1111, 1'b0, 32'h0000_0000, 28'h082AF34},
        '{1'b0, 2'b11, 20'hABCD, 4'b0110, 1'b1, 32'h1111_0003, 28'h0C2AF34},
        '{1'b1, 2'b00, 20'hABCD, 4'b1111, 1'b0, 32'h0000_0000, 28'h102AF34},
        '{1'b1, 2'b01, 20'hABCD, 4'b1100, 1'b1, 32'h1111_0005, 28'h142AF34},
        '{1'b1, 2'b10, 20'hABCD, 4'b1111, 1'b0, 32'h0000_0000, 28'h182AF34},
        '{1'b1, 2'b11, 20'hABCD, 4'b1000, 1'b1, 32'h1111_0007, 28'h1C2AF34}
    };

    // Results of the last access
    logic        r_v, r_d, r_we, r_busy_mid;
    logic [27:0] r_addr;
    logic [3:0]  r_be;
    logic [31:0] r_wd, r_rd;

    task automatic access(input bit pg, input bit lo, input bit hi, input logic [1:0] c,
                          input logic [19:0] w, input logic [3:0] b, input bit wr,
                          input logic [31:0] d, input int lat, input bit poke);
        bit pend = 0;
        int cnt = 0;
        r_v = 0; r_d = 0; r_busy_mid = 0;
        @(negedge clk);
        cs_lo = lo; cs_hi = hi; ctl = c; word = w; be = b; we = wr; wdata = d;
        if (pg) req_p = 1; else req_s = 1;
        @(negedge clk);
        req_p = 0; req_s = 0;
        for (int i = 0; i < 16; i++) begin
            rdy_s = 0; rdy_p = 0; req_p = 0;
            if (pg ? p_done : s_done) begin
                r_d  = 1;
                r_rd = pg ? p_rdata : s_rdata;
                break;
            end
            if (pg ? p_valid : s_valid) begin
                r_v = 1; pend = 1; cnt = lat;
                r_addr = pg ? p_addr : s_addr;
                r_be   = pg ? p_be : s_be;
                r_we   = pg ? p_we : s_we;
                r_wd   = pg ? p_wd : s_wd;
                if (poke) begin
                    cs_lo = 0; cs_hi = 1; we = 1; wdata = 32'h3F; req_p = 1;
                end
            end else if (pend && cnt > 0) begin
                r_busy_mid = pg ? p_busy : s_busy;
            end
            if (pend) begin
                if (cnt == 0) begin
                    if (pg) rdy_p = 1; else rdy_s = 1;
                    pend = 0;
                end else cnt--;
            end
            @(negedge clk);
        end
        rdy_s = 0; rdy_p = 0; req_p = 0; req_s = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {63'b0, s_busy}, 64'd0);
        chk("R1 done", {63'b0, s_done | p_done}, 64'd0);
        chk("R1 valid", {63'b0, s_valid | p_valid}, 64'd0);
        rst_n = 1;
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 0, 32'h0, 0, 0);
        chk("R1 page reset readback", {32'b0, r_rd}, 64'd0);

        // R2/R5/R6 table walk
        foreach (VECS[i]) begin
            mrdata = 32'hC0DE_0000 | 32'(i);
            access(0, !VECS[i].hi, VECS[i].hi, VECS[i].ctl, VECS[i].word, VECS[i].be,
                   VECS[i].we, VECS[i].wdata, i % 3, 0);
            chk($sformatf("R2 seg%0d addr", i), {36'b0, r_addr}, {36'b0, VECS[i].exp_addr});
            chk($sformatf("R5 seg%0d be", i), {60'b0, r_be}, {60'b0, VECS[i].be});
            chk($sformatf("R5 seg%0d we", i), {63'b0, r_we}, {63'b0, VECS[i].we});
            if (VECS[i].we)
                chk($sformatf("R5 seg%0d wdata", i), {32'b0, r_wd}, {32'b0, VECS[i].wdata});
            else
                chk($sformatf("R6 seg%0d rdata", i), {32'b0, r_rd}, {32'b0, mrdata});
            chk($sformatf("R6 seg%0d done", i), {63'b0, r_d}, 64'd1);
        end

        // R2 both selects: upper wins
        access(0, 1, 1, 2'b10, 20'h00010, 4'hF, 0, 0, 0, 0);
        chk("R2 both selects", {36'b0, r_addr}, {36'b0, 28'h1800040});

        // R7 busy stretched while waiting for ready
        access(0, 1, 0, 2'b00, 20'h1, 4'hF, 0, 0, 4, 0);
        chk("R7 busy during wait", {63'b0, r_busy_mid}, 64'd1);

        // R8 no chip-select
        access(0, 0, 0, 2'b01, 20'h5, 4'hF, 1, 32'h55, 0, 0);
        chk("R8 no request", {63'b0, r_v}, 64'd0);
        chk("R8 no done", {63'b0, r_d}, 64'd0);
        chk("R8 not busy", {63'b0, s_busy}, 64'd0);

        // R3 page 0, ctl ignored
        access(1, 1, 0, 2'b11, 20'hABCD, 4'hF, 0, 0, 0, 0);
        chk("R3 ctl ignored", {36'b0, r_addr}, {36'b0, 28'h002AF34});

        // R4 page write, no memory request, readback zero-extended
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 1, 32'hFFFF_FFEA, 0, 0);
        chk("R4 page write no mem", {63'b0, r_v}, 64'd0);
        chk("R4 page write done", {63'b0, r_d}, 64'd1);
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 0, 0, 0, 0);
        chk("R4 page readback", {32'b0, r_rd}, 64'h2A);
        access(1, 1, 0, 2'b00, 20'hABCD, 4'b0011, 1, 32'hAA55, 1, 0);
        chk("R3 paged addr", {36'b0, r_addr}, {36'b0, 28'hA82AF34});
        chk("R5 paged partial be", {60'b0, r_be}, 64'h3);

        // R7 page change between two accesses; page write while busy ignored
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 1, 32'h5, 0, 0);
        access(1, 1, 0, 2'b00, 20'h00010, 4'hF, 0, 0, 2, 1);
        chk("R7 access before change", {36'b0, r_addr}, {36'b0, 28'h1400040});
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 0, 0, 0, 0);
        chk("R7 in-flight page write ignored", {32'b0, r_rd}, 64'h5);
        access(1, 0, 1, 2'b00, 20'h0, 4'hF, 1, 32'h9, 0, 0);
        access(1, 1, 0, 2'b00, 20'h00010, 4'hF, 0, 0, 0, 0);
        chk("R7 access after change", {36'b0, r_addr}, {36'b0, 28'h2400040});

        // R9 address held while waiting
        access(0, 1, 0, 2'b01, 20'h00020, 4'hF, 0, 0, 3, 0);
        chk("R9 addr held", {36'b0, s_addr}, {36'b0, 28'h0400080});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule